// File: doc/BRIEF.md
# Logic analyzer serial command decoder

This block sits behind a UART receiver and turns its byte stream into logic analyzer commands. A command starts with an opcode byte. When bit 7 of the opcode is clear, the command is that byte alone. When bit 7 is set, four argument bytes follow, and the first of them is the least significant byte of a 32-bit argument. Each finished command leaves the block as a one-cycle strobe carrying the opcode and the assembled argument. Short commands carry an argument of zero.

The opcode 0x00 is the reset command. The host sends it five times in a row, which brings the framing back to a command boundary wherever it stood inside a long command. Every reset byte seen at a boundary also raises a one-cycle soft reset for the downstream capture logic.

The opcode 0x02 is the identify request. The block answers it by pushing a fixed four-byte signature through a ready/valid transmit byte interface. Command decoding carries on while the reply is being sent, so no command is lost during that time.

Top module: `la_cmd_decoder`

## Requirements
- R1: After reset, cmd_valid_o, soft_reset_o and tx_valid_o are all low.
- R2: An accepted byte with bit 7 = 0 at a command boundary makes cmd_valid_o high for one cycle, in the cycle after the byte is accepted. That cycle carries the byte on cmd_opcode_o and zero on cmd_arg_o.
- R3: An accepted byte with bit 7 = 1 at a boundary starts a long command that takes four more accepted bytes. The first of them becomes cmd_arg_o[7:0] and the fourth becomes cmd_arg_o[31:24]. The command is emitted in the cycle after the fourth argument byte.
- R4: A 0x00 byte at a boundary is emitted as a short command with opcode 0x00, and soft_reset_o is high in that same cycle.
- R5: Five consecutive 0x00 bytes return the framing to a boundary from any position, and they raise soft_reset_o at least once. The next opcode is then decoded correctly.
- R6: A 0x02 byte at a boundary starts a reply of the bytes 0x31, 0x53, 0x4C, 0x4F, sent in that order. tx_valid_o rises in the second cycle after the byte is accepted.
- R7: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o holds its value.
- R8: Commands that arrive while a reply is in progress are still emitted. One identify request that arrives during a reply causes a second full reply after the first.
- R9: The bytes 0x00 and 0x02, when they are argument bytes of a long command, raise no soft reset and start no reply.
- R10: Idle cycles with rx_valid_i low between bytes do not change the framing or the assembled argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| cmd_valid_o | output | 1 | One-cycle strobe for a complete command |
| cmd_opcode_o | output | 8 | Opcode of the emitted command |
| cmd_arg_o | output | 32 | Argument of the emitted command, zero for short commands |
| soft_reset_o | output | 1 | One-cycle pulse for a reset byte at a boundary |
| tx_valid_o | output | 1 | A reply byte is offered |
| tx_data_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |

## Verification
A byte counter that has slipped shows up at the ports within one command. Either an opcode is taken as an argument byte, or an argument is emitted with its bytes shifted by one lane. A comparison of every strobe against a byte-serial reference model catches this at the next emitted command. A reply sequencer in the wrong state shows up as a signature byte skipped, repeated or changed during a stall. The ordered record of handshaked transmit bytes exposes it as soon as the reply completes. A mistaken boundary test would also raise soft resets or replies from argument bytes, and the soft reset count and the reply byte count reveal this by the end of the run.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam logic [7:0] OP_SOFT_RESET = 8'h00;
  localparam logic [7:0] OP_IDENTIFY   = 8'h02;
  localparam int unsigned LONG_FLAG_BIT = 7;
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
  import la_cmd_pkg::*;
#(
  parameter int unsigned ARG_BYTES = 4,
  localparam int unsigned ARG_W = 8 * ARG_BYTES,
  localparam int unsigned CNT_W = $clog2(ARG_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_opcode_o,
  output logic [ARG_W-1:0] cmd_arg_o,
  output logic             soft_reset_o,
  output logic             id_req_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ARG_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       op_q;
  logic [ARG_W-1:0] arg_q, arg_nxt;

  // lane i is written by argument byte i+1
  for (genvar i = 0; i < ARG_BYTES; i++) begin : g_lane
    assign arg_nxt[8*i +: 8] = (cnt_q == CNT_W'(i + 1)) ? rx_data_i : arg_q[8*i +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      op_q         <= '0;
      arg_q        <= '0;
      cmd_valid_o  <= 1'b0;
      cmd_opcode_o <= '0;
      cmd_arg_o    <= '0;
      soft_reset_o <= 1'b0;
      id_req_o     <= 1'b0;
    end else begin
      cmd_valid_o  <= 1'b0;
      soft_reset_o <= 1'b0;
      id_req_o     <= 1'b0;
      if (rx_valid_i) begin
        if (cnt_q == '0) begin
          if (rx_data_i[LONG_FLAG_BIT]) begin
            op_q  <= rx_data_i;
            arg_q <= '0;
            cnt_q <= CNT_W'(1);
          end else begin
            cmd_valid_o  <= 1'b1;
            cmd_opcode_o <= rx_data_i;
            cmd_arg_o    <= '0;
            soft_reset_o <= (rx_data_i == OP_SOFT_RESET);
            id_req_o     <= (rx_data_i == OP_IDENTIFY);
          end
        end else begin
          arg_q <= arg_nxt;
          if (cnt_q == LAST_POS) begin
            cmd_valid_o  <= 1'b1;
            cmd_opcode_o <= op_q;
            cmd_arg_o    <= arg_nxt;
            cnt_q        <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_POS);
  p_cmd_needs_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(rx_valid_i));
  p_soft_reset_short_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_reset_o |-> (cmd_valid_o && cmd_opcode_o == OP_SOFT_RESET && cmd_arg_o == '0));
endmodule

// File: rtl/la_id_responder.sv
module la_id_responder #(
  parameter int unsigned SIG_BYTES = 4,
  parameter logic [8*SIG_BYTES-1:0] SIGNATURE = 32'h4F4C5331,
  localparam int unsigned IDX_W = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       id_req_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SIG_BYTES - 1);

  logic             busy_q, pend_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire;

  assign fire       = busy_q && tx_ready_i;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = SIGNATURE[8*idx_q +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (id_req_i || pend_q) begin
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        idx_q  <= '0;
      end
    end else if (fire && idx_q == LAST_IDX) begin
      // back-to-back reply when another request is waiting
      idx_q  <= '0;
      busy_q <= id_req_i || pend_q;
      pend_q <= 1'b0;
    end else begin
      if (fire) idx_q <= idx_q + IDX_W'(1);
      if (id_req_i) pend_q <= 1'b1;
    end
  end

  p_hold_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  p_reply_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_req_i && !tx_valid_o) |=> (tx_valid_o && tx_data_o == SIGNATURE[7:0]));
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder #(
  parameter int unsigned ARG_BYTES = 4,
  parameter logic [31:0] SIGNATURE = 32'h4F4C5331
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rx_valid_i,
  input  logic [7:0]             rx_data_i,
  output logic                   cmd_valid_o,
  output logic [7:0]             cmd_opcode_o,
  output logic [8*ARG_BYTES-1:0] cmd_arg_o,
  output logic                   soft_reset_o,
  output logic                   tx_valid_o,
  output logic [7:0]             tx_data_o,
  input  logic                   tx_ready_i
);
  logic id_req;

  la_cmd_framer #(.ARG_BYTES(ARG_BYTES)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_opcode_o(cmd_opcode_o),
    .cmd_arg_o   (cmd_arg_o),
    .soft_reset_o(soft_reset_o),
    .id_req_o    (id_req)
  );

  la_id_responder #(.SIG_BYTES(4), .SIGNATURE(SIGNATURE)) u_responder (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_req_i  (id_req),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .tx_ready_i(tx_ready_i)
  );

  p_reply_needs_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(id_req));
endmodule

// File: tb/la_cmd_decoder_bench.sv
module la_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = 8'h00;
  logic        tx_ready_i = 1'b0;
  logic        cmd_valid_o, soft_reset_o, tx_valid_o;
  logic [7:0]  cmd_opcode_o, tx_data_o;
  logic [31:0] cmd_arg_o;

  la_cmd_decoder u_la_cmd_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .cmd_valid_o(cmd_valid_o), .cmd_opcode_o(cmd_opcode_o), .cmd_arg_o(cmd_arg_o),
    .soft_reset_o(soft_reset_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_ready_i(tx_ready_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit reported = 0;
  int ready_mode = 0;  // 0 low, 1 high, 2 random
  int sr_seen = 0, exp_sr = 0;
  logic [39:0] got_cmd[$], exp_cmd[$];
  logic [7:0]  got_tx[$], exp_tx[$];
  int m_cnt = 0;
  logic [7:0]  m_op = 0;
  logic [31:0] m_arg = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference model of the framing rules, one call per accepted byte
  task automatic model_byte(input logic [7:0] b);
    if (m_cnt == 0) begin
      if (b[7]) begin
        m_op = b; m_arg = 0; m_cnt = 1;
      end else begin
        exp_cmd.push_back({b, 32'h0});
        if (b == 8'h00) exp_sr++;
        if (b == 8'h02) begin
          exp_tx.push_back(8'h31); exp_tx.push_back(8'h53);
          exp_tx.push_back(8'h4C); exp_tx.push_back(8'h4F);
        end
      end
    end else begin
      m_arg[8*(m_cnt-1) +: 8] = b;
      if (m_cnt == 4) begin
        exp_cmd.push_back({m_op, m_arg});
        m_cnt = 0;
      end else m_cnt++;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    model_byte(b);
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  // monitor: sets tx_ready for the coming edge, records handshakes and strobes
  initial begin
    forever begin
      @(negedge clk_i);
      case (ready_mode)
        0: tx_ready_i = 1'b0;
        1: tx_ready_i = 1'b1;
        default: tx_ready_i = ($urandom % 10) < 7;
      endcase
      if (rst_ni) begin
        if (tx_valid_o && tx_ready_i) got_tx.push_back(tx_data_o);
        if (cmd_valid_o) got_cmd.push_back({cmd_opcode_o, cmd_arg_o});
        if (soft_reset_o) sr_seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int sr_before;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!cmd_valid_o && !soft_reset_o && !tx_valid_o, "R1 reset", {cmd_valid_o, soft_reset_o, tx_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cmd_valid_o && !soft_reset_o && !tx_valid_o, "R1 after release", {cmd_valid_o, soft_reset_o, tx_valid_o}, 0);

    send_byte(8'h05, 0);
    chk(cmd_valid_o && cmd_opcode_o == 8'h05 && cmd_arg_o == 0, "R2 short", {cmd_valid_o, cmd_opcode_o, cmd_arg_o}, {1'b1, 8'h05, 32'h0});
    @(negedge clk_i);
    chk(!cmd_valid_o, "R2 one cycle", cmd_valid_o, 0);

    send_byte(8'h81, 0); send_byte(8'h44, 0); send_byte(8'h33, 0); send_byte(8'h22, 0);
    chk(!cmd_valid_o, "R3 not before last byte", cmd_valid_o, 0);
    send_byte(8'h11, 0);
    chk(cmd_valid_o && cmd_opcode_o == 8'h81 && cmd_arg_o == 32'h11223344, "R3 long", {cmd_opcode_o, cmd_arg_o}, {8'h81, 32'h11223344});

    send_byte(8'h00, 0);
    chk(soft_reset_o && cmd_valid_o && cmd_opcode_o == 8'h00, "R4 soft reset", {soft_reset_o, cmd_valid_o, cmd_opcode_o}, {2'b11, 8'h00});

    // identify with transmitter stalled
    send_byte(8'h02, 0);
    chk(!tx_valid_o, "R6 not yet valid", tx_valid_o, 0);
    @(negedge clk_i);
    chk(tx_valid_o && tx_data_o == 8'h31, "R6 first byte timing", {tx_valid_o, tx_data_o}, {1'b1, 8'h31});
    send_byte(8'h11, 0);
    chk(cmd_valid_o && cmd_opcode_o == 8'h11, "R8 command during reply", {cmd_valid_o, cmd_opcode_o}, {1'b1, 8'h11});
    send_byte(8'h02, 3);
    chk(tx_valid_o && tx_data_o == 8'h31, "R7 held while stalled", {tx_valid_o, tx_data_o}, {1'b1, 8'h31});
    ready_mode = 2;
    repeat (40) @(negedge clk_i);
    chk(!tx_valid_o, "R8 replies drained", tx_valid_o, 0);

    // resync from inside a long command
    send_byte(8'h80, 1); send_byte(8'hAA, 0);
    sr_before = sr_seen;
    for (int k = 0; k < 5; k++) send_byte(8'h00, k % 2);
    chk(sr_seen > sr_before, "R5 soft reset seen", sr_seen - sr_before, 1);
    send_byte(8'h07, 0);
    chk(cmd_valid_o && cmd_opcode_o == 8'h07 && cmd_arg_o == 0, "R5 next opcode", {cmd_opcode_o, cmd_arg_o}, {8'h07, 32'h0});

    // special bytes as arguments, with idle gaps
    sr_before = sr_seen;
    send_byte(8'h83, 2); send_byte(8'h00, 0); send_byte(8'h02, 3); send_byte(8'h00, 1); send_byte(8'h02, 0);
    chk(cmd_valid_o && cmd_arg_o == 32'h02000200, "R10 gaps keep framing", cmd_arg_o, 32'h02000200);
    repeat (6) @(negedge clk_i);
    chk(sr_seen == sr_before && !tx_valid_o, "R9 args inert", {sr_seen - sr_before, tx_valid_o}, 0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (m_cnt == 0) begin
        if (($urandom % 10) < 3) b[7] = 1'b1;
        else begin
          b[7] = 1'b0;
          if (b == 8'h02) b = 8'h03;
        end
      end
      send_byte(b, $urandom % 3);
    end
    ready_mode = 1;
    repeat (20) @(negedge clk_i);

    chk(got_cmd.size() == exp_cmd.size(), "R2 R3 command count", got_cmd.size(), exp_cmd.size());
    for (int i = 0; i < exp_cmd.size() && i < got_cmd.size(); i++)
      chk(got_cmd[i] == exp_cmd[i], "R3 R10 command stream", got_cmd[i], exp_cmd[i]);
    chk(sr_seen == exp_sr, "R4 R9 soft reset count", sr_seen, exp_sr);
    chk(got_tx.size() == exp_tx.size(), "R6 R8 reply length", got_tx.size(), exp_tx.size());
    for (int i = 0; i < exp_tx.size() && i < got_tx.size(); i++)
      chk(got_tx[i] == exp_tx[i], "R6 R7 reply bytes", got_tx[i], exp_tx[i]);
    report();
  end
endmodule